// File: doc/BRIEF.md
# Per-Thread Hardware Stack Bank with Sticky Fault Flags

This block holds one last-in-first-out stack for each hardware thread of an interleaved multi-thread core. In any cycle the core names one thread and may push a word, pop a word, or do both at once. Doing both replaces the top entry. The word at the top of the named thread's stack is always visible on the read output.

A push onto a full stack is an overflow and a pop from an empty stack is an underflow. The block records each such event in a sticky bit that belongs to the offending thread. All these bits sit in one status word. Software reads the word directly and clears individual bits by writing ones to them. A single clear command empties every stack at the same moment.

Top module: `thread_stack_bank`

## Requirements
- R1: After synchronous reset every stack is empty and the status word reads zero.
- R2: Pops return words in the reverse of the order they were pushed. `top_data` shows the most recent word that has not been popped from the selected thread's stack.
- R3: A stack accepts exactly DEPTH (default 32) pushes without error. A push-only on a full stack sets status bit THREADS+thread (bit 8+thread by default), discards the data and leaves the contents and depth unchanged.
- R4: A pop-only on an empty stack sets status bit `thread` (bits 7:0 by default), and the stack stays empty.
- R5: A combined pop and push on a full stack is legal. It overwrites the top entry and raises no flag.
- R6: A combined pop and push on a non-empty stack overwrites the top and keeps the depth. On an empty stack it sets the underflow bit of that thread and leaves the pushed word as the only entry.
- R7: `clr_all` empties all stacks in one cycle. It leaves the status word untouched, and a push or pop presented in the same cycle is ignored.
- R8: Status bits stay set until software writes 1 to them through `st_wr`/`st_wdata`. Bits written with 0 keep their value.
- R9: A fault event and a software clear of the same bit in the same cycle leave that bit set.
- R10: Each thread has its own depth. Operations on one thread do not change another thread's contents or depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tid | input | $clog2(THREADS) | Thread selected this cycle |
| push | input | 1 | Push `push_data` onto the selected stack |
| pop | input | 1 | Pop the selected stack |
| push_data | input | DW | Word to push |
| top_data | output | DW | Top word of the selected stack (stable but meaningless when it is empty) |
| clr_all | input | 1 | Empty every stack |
| st_wr | input | 1 | Write-one-to-clear strobe for the status word |
| st_wdata | input | 2*THREADS | Bits to clear |
| st_rdata | output | 2*THREADS | Status word: underflow bits low, overflow bits high |

## Verification
Directed runs fill one stack to its exact capacity and push once more. They pop it down to empty and pop once more. These runs separate an off-by-one depth limit from a correct one, and a correct flag position from a swapped one. Combined pop-and-push is applied on a full, a partly filled and an empty stack, which separates top replacement from pointer motion. A clear collides with a push, and a software clear collides with a fresh fault, to expose the wrong priority in either case. Random traffic then spreads push-heavy, pop-heavy and mixed phases over all threads with occasional clears and status writes, which catches any leak between threads.

// File: rtl/thread_stack_bank.sv
module thread_stack_bank #(
  parameter int THREADS = 8,
  parameter int DEPTH   = 32,
  parameter int DW      = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [$clog2(THREADS)-1:0]   tid,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                push_data,
  output logic [DW-1:0]                top_data,
  input  logic                         clr_all,
  input  logic                         st_wr,
  input  logic [2*THREADS-1:0]         st_wdata,
  output logic [2*THREADS-1:0]         st_rdata
);
  localparam int TW = $clog2(THREADS);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int EW = 2 * THREADS;

  logic [DW-1:0] mem [THREADS][DEPTH];
  logic [PW-1:0] cnt [THREADS];
  logic [EW-1:0] flags;
  logic [EW-1:0] events;

  logic [PW-1:0] sel_cnt;
  assign sel_cnt = cnt[tid];

  wire empty     = (sel_cnt == '0);
  wire full      = (sel_cnt == PW'(DEPTH));
  wire op_ok     = ~clr_all;
  wire swap      = op_ok & push & pop;
  wire push_only = op_ok & push & ~pop;
  wire pop_only  = op_ok & pop & ~push;
  wire ovf       = push_only & full;
  wire unf       = op_ok & pop & empty;

  wire [AW-1:0] top_idx = empty ? '0 : AW'(sel_cnt - PW'(1));
  wire [AW-1:0] wr_idx  = swap ? top_idx : AW'(sel_cnt);
  wire          wr_en   = swap | (push_only & ~full);

  assign top_data = mem[tid][top_idx];
  assign st_rdata = flags;

  always_comb begin
    events = '0;
    events[tid] = unf;
    events[THREADS + int'(tid)] = ovf;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[tid][wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      for (int i = 0; i < THREADS; i++) cnt[i] <= '0;
    end else if (push_only && !full) begin
      cnt[tid] <= sel_cnt + PW'(1);
    end else if (pop_only && !empty) begin
      cnt[tid] <= sel_cnt - PW'(1);
    end else if (swap && empty) begin
      cnt[tid] <= PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~(st_wr ? st_wdata : '0)) | events;
  end
endmodule

module thread_stack_bank_chk #(
  parameter int THREADS = 8,
  parameter int DEPTH   = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(THREADS)-1:0] tid,
  input logic                       push,
  input logic                       pop,
  input logic                       clr_all,
  input logic                       st_wr,
  input logic [2*THREADS-1:0]       st_rdata,
  input logic [$clog2(DEPTH+1)-1:0] sel_cnt
);
  localparam int PW = $clog2(DEPTH + 1);
  logic [$clog2(THREADS)-1:0] tid_q;
  always_ff @(posedge clk) tid_q <= tid;

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> st_rdata == '0);

  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (rst)
    sel_cnt <= PW'(DEPTH));

  assert_overflow_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr_all && sel_cnt == PW'(DEPTH)) |=> st_rdata[THREADS + int'(tid_q)]);

  assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !clr_all && sel_cnt == '0) |=> st_rdata[tid_q]);

  assert_swap_full_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !clr_all && !st_wr && sel_cnt != '0) |=> st_rdata == $past(st_rdata));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> sel_cnt == '0);

  assert_clear_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !st_wr) |=> st_rdata == $past(st_rdata));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !st_wr |=> (st_rdata & $past(st_rdata)) == $past(st_rdata));
endmodule

bind thread_stack_bank thread_stack_bank_chk #(.THREADS(THREADS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tid(tid), .push(push), .pop(pop), .clr_all(clr_all),
  .st_wr(st_wr), .st_rdata(st_rdata), .sel_cnt(sel_cnt)
);

// File: tb/thread_stack_bank_bench.sv
module thread_stack_bank_bench;
  localparam int T = 8;
  localparam int D = 32;
  localparam int W = 16;

  logic clk = 0, rst = 1;
  logic [2:0] tid = '0;
  logic push = 0, pop = 0, clr_all = 0, st_wr = 0;
  logic [W-1:0] push_data = '0, top_data;
  logic [2*T-1:0] st_wdata = '0, st_rdata;

  always #2 clk = ~clk;

  thread_stack_bank u_thread_stack_bank (.*);

  logic [W-1:0] m_mem [T][D];
  int m_cnt [T];
  logic [2*T-1:0] m_flags;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [2*T-1:0] model_step(int t, bit pu, bit po, logic [W-1:0] d,
                                                 bit clr, bit ew, logic [2*T-1:0] wd);
    logic [2*T-1:0] ev = '0;
    if (clr) begin
      for (int i = 0; i < T; i++) m_cnt[i] = 0;
    end else if (pu && po) begin
      if (m_cnt[t] == 0) begin ev[t] = 1; m_mem[t][0] = d; m_cnt[t] = 1; end
      else m_mem[t][m_cnt[t]-1] = d;
    end else if (pu) begin
      if (m_cnt[t] == D) ev[T+t] = 1;
      else begin m_mem[t][m_cnt[t]] = d; m_cnt[t]++; end
    end else if (po) begin
      if (m_cnt[t] == 0) ev[t] = 1; else m_cnt[t]--;
    end
    return (m_flags & ~(ew ? wd : '0)) | ev;
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(int t, bit pu, bit po, logic [W-1:0] d, bit clr,
                      bit ew, logic [2*T-1:0] wd, string req);
    @(negedge clk);
    tid = t[2:0]; push = pu; pop = po; push_data = d; clr_all = clr; st_wr = ew; st_wdata = wd;
    @(posedge clk);
    m_flags = model_step(t, pu, po, d, clr, ew, wd);
    #1;
    check(req, "status", st_rdata, m_flags);
    if (m_cnt[t] > 0) check(req, "top", top_data, m_mem[t][m_cnt[t]-1]);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < T; i++) m_cnt[i] = 0;
    m_flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 check("R1", "status after reset", st_rdata, '0);
    for (int i = 0; i < T; i++) step(i, 0, 1, 0, 0, 0, 0, "R1 R4 empty pop");
    step(0, 0, 0, 0, 0, 1, 16'h00ff, "R8 clear all underflow");

    for (int i = 0; i < D; i++) step(3, 1, 0, W'(16'h3000 + i), 0, 0, 0, "R3 R2 fill");
    step(3, 1, 0, 16'hdead, 0, 0, 0, "R3 overflow");
    step(6, 1, 0, 16'h6006, 0, 0, 0, "R10 other thread");
    step(3, 0, 0, 0, 0, 1, 16'h0000, "R8 write zero");
    step(3, 0, 0, 0, 0, 1, 16'h0800, "R8 write one");
    step(3, 1, 1, 16'hbeef, 0, 0, 0, "R5 swap full");
    for (int i = 0; i < D; i++) step(3, 0, 1, 0, 0, 0, 0, "R2 drain");
    step(3, 0, 1, 0, 0, 0, 0, "R4 extra pop");
    step(6, 1, 1, 16'h6116, 0, 0, 0, "R6 swap nonempty");
    step(5, 1, 1, 16'h5555, 0, 0, 0, "R6 swap empty");
    step(5, 0, 1, 0, 0, 0, 0, "R6 depth one");
    step(5, 0, 1, 0, 0, 1, 16'h0020, "R9 event beats clear");

    for (int i = 0; i < D; i++) step(2, 1, 0, W'(16'h2000 + i), 0, 0, 0, "R3 fill");
    step(2, 1, 0, 16'h1111, 1, 0, 0, "R7 clear with push");
    step(6, 0, 1, 0, 0, 0, 0, "R7 other thread emptied");
    for (int i = 0; i < D; i++) step(2, 1, 0, W'(16'h2100 + i), 0, 0, 0, "R7 refill");
    step(2, 1, 0, 16'h2222, 0, 0, 0, "R3 overflow after clear");
    step(2, 0, 0, 0, 1, 0, 0, "R7 clear keeps flags");

    for (int ph = 0; ph < 3; ph++) begin
      for (int k = 0; k < 600; k++) begin
        int t = $urandom_range(T - 1);
        int r = $urandom_range(99);
        bit pu = (ph == 0) ? (r < 80) : (ph == 1) ? (r < 25) : (r < 50);
        bit po = (ph == 0) ? (r > 90) : (ph == 1) ? (r > 20) : (r > 40);
        bit clr = ($urandom_range(59) == 0);
        bit ew = ($urandom_range(9) == 0);
        step(t, pu, po, W'($urandom), clr, ew, (2*T)'($urandom), "R2 R10 random");
      end
    end
    @(negedge clk);
    push = 0; pop = 0; clr_all = 0; st_wr = 0;
    summary();
  end
endmodule